// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is one DMA channel that moves 32-bit words between a memory buffer and a fixed device address. It works through a list of descriptors held in memory. Software starts the channel with a single write to its control word. That word carries the address of the first descriptor, a channel number and a start bit. The channel then reads each seven-word descriptor over a word-wide memory port and moves the words in the direction the descriptor selects. When a descriptor is finished, the channel writes its command word back with completion flags, raises an optional interrupt and follows the next pointer. A next pointer of zero ends the run.

The memory port is a request/acknowledge pair. The request and its address, direction and write data stay steady until a one-cycle acknowledge arrives. Read data comes back in the same cycle as the acknowledge. On the device side, words come in through a valid/ready pair and go out through a second valid/ready pair. Between bursts the channel can step over a gap in memory, so it can gather several bursts from a strided layout in one descriptor. A stop request ends the run cleanly at the next word boundary.

Top module: `chain_dma`

## Requirements
- R1: A control write with bit 3 (start) set while the channel is idle begins a run. The descriptor pointer is taken from bits 31:6 with the low six bits forced to zero. The channel number is taken from bits 1:0 and appears on `chan_id`. `busy` rises on the clock edge that captures the write.
- R2: A descriptor is read as seven words at byte offsets 0, 4, 8, 12, 16, 20 and 24 from its pointer. These words are, in that order: next pointer, memory address, device address, length, stride, repeat count, command. The device address word drives `dev_addr`.
- R3: When command bit 12 is 1, the channel reads words from memory starting at the memory address and presents them in ascending address order on the device output.
- R4: When command bit 12 is 0, the channel takes words from the device input and writes them to memory at ascending word addresses starting at the memory address.
- R5: The length counts 32-bit words, not bytes. A length of zero moves no data, but the descriptor still completes and writes back.
- R6: A repeat count N greater than 1 runs N bursts of length words each. Between bursts the memory address moves on by length plus stride words from the start of the previous burst. A repeat count of 0 or 1 gives one burst.
- R7: After a descriptor's data has moved, the channel writes its command word to byte offset 24 of that descriptor with bit 2 set. It also sets bit 3 when the next pointer is zero.
- R8: `irq` pulses high for exactly one cycle after a write-back if command bit 1 is 1 and bit 0 is 0. Otherwise it stays low.
- R9: A non-zero next pointer (bits 31:6) is fetched and executed with no further control write. After the write-back of a descriptor whose next pointer is zero, `busy` falls and the memory and device ports go quiet.
- R10: A control write with bit 4 (stop) while busy ends the run after the word in flight completes. No further data moves, the current descriptor is not written back, no interrupt is raised and `busy` falls.
- R11: A control write with the start bit set while busy is ignored. The run in progress continues unchanged, `chan_id` keeps its value, and no second run follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word: pointer, start, stop, channel number |
| busy | output | 1 | Channel is running a descriptor chain |
| chan_id | output | ID_W | Channel number from the last accepted start |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access complete, one cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| dev_addr | output | 32 | Device address of the current descriptor |
| dev_in_valid | input | 1 | Device offers a word |
| dev_in_data | input | 32 | Word from the device |
| dev_in_ready | output | 1 | Channel accepts the device word |
| dev_out_valid | output | 1 | Channel offers a word to the device |
| dev_out_data | output | 32 | Word to the device |
| dev_out_ready | input | 1 | Device accepts the word |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The bench builds the channel with its default two-bit channel number and a 1 KiB behavioural memory. In that memory, four descriptor slots and the buffers fit together with room for sentinel words around each buffer. The memory answers every request one cycle later. Device ready and valid can run at full rate or be throttled, so both the memory-side and device-side stall paths are exercised. With the small memory, chains of one to four descriptors are reachable, along with mixed directions, zero-length and strided repeated bursts, a masked interrupt, and a stop landing in the middle of a slow device-to-memory transfer.

// File: rtl/chain_dma_pkg.sv
// Shared constants and types for the descriptor-chained DMA channel.
// Assumes 32-bit words, byte addressing and 64-byte aligned descriptors.
package chain_dma_pkg;

    localparam int WORD_W      = 32;
    localparam int DESC_WORDS  = 7;
    localparam int PTR_LSB     = 6;

    // control word bit positions
    localparam int CTL_START   = 3;
    localparam int CTL_STOP    = 4;

    // command word bit positions
    localparam int CMD_IRQ_MSK = 0;
    localparam int CMD_IRQ_EN  = 1;
    localparam int CMD_DESC_OK = 2;
    localparam int CMD_ALL_OK  = 3;
    localparam int CMD_TO_DEV  = 12;

    // byte offset of the command word inside a descriptor
    localparam logic [WORD_W-1:0] CMD_OFFS = WORD_W'((DESC_WORDS - 1) * 4);
    localparam logic [WORD_W-1:0] PTR_MASK = {{(WORD_W-PTR_LSB){1'b1}}, {PTR_LSB{1'b0}}};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_RD,
        ST_WR,
        ST_WB
    } dma_state_t;

endpackage

// File: rtl/chain_dma_ctl.sv
// Control word decoder. It accepts a start only while the channel is
// idle, latches the aligned descriptor pointer and the channel number,
// and holds a stop request until the sequencer returns to idle.
// Assumes ID_W is at most 3, so the channel number stays below the start bit.
module chain_dma_ctl
    import chain_dma_pkg::*;
#(
    parameter int ID_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [WORD_W-1:0] ctl_wdata,
    input  logic              seq_busy,
    output logic              go,
    output logic [WORD_W-1:0] go_ptr,
    output logic [ID_W-1:0]   chan_id,
    output logic              stop_pend,
    output logic              busy_any
);

    logic start_acc;
    logic ctl_unused;

    assign busy_any   = seq_busy | go;
    assign start_acc  = ctl_we & ctl_wdata[CTL_START] & ~busy_any;
    assign ctl_unused = ^ctl_wdata[PTR_LSB-1:ID_W];

    // capture an accepted start and hand a one-cycle go to the sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go      <= 1'b0;
            go_ptr  <= '0;
            chan_id <= '0;
        end else begin
            go <= start_acc;
            if (start_acc) begin
                go_ptr  <= ctl_wdata & PTR_MASK;
                chan_id <= ctl_wdata[ID_W-1:0];
            end
        end
    end

    // hold a stop request made while running, drop it once idle
    always_ff @(posedge clk) begin
        if (!rst_n)
            stop_pend <= 1'b0;
        else if (ctl_we && ctl_wdata[CTL_STOP] && busy_any)
            stop_pend <= 1'b1;
        else if (!busy_any)
            stop_pend <= 1'b0;
    end

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy_any |=> $stable(chan_id));                                  // R11
    AST_STOP_IDLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_any |=> !stop_pend);                                       // R10

endmodule

// File: rtl/chain_dma_seq.sv
// Descriptor sequencer. It fetches seven descriptor words, moves data one
// word at a time (a read phase, then a write phase) in the selected
// direction, repeats bursts with a stride, writes the command word back,
// raises the interrupt and follows the chain.
// Assumes the memory holds a request steady until its one-cycle acknowledge.
module chain_dma_seq
    import chain_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [WORD_W-1:0] go_ptr,
    input  logic              stop_pend,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] dev_addr,
    input  logic              dev_in_valid,
    input  logic [WORD_W-1:0] dev_in_data,
    output logic              dev_in_ready,
    output logic              dev_out_valid,
    output logic [WORD_W-1:0] dev_out_data,
    input  logic              dev_out_ready,
    output logic              irq
);

    dma_state_t        state;
    logic [2:0]        idx;
    logic [WORD_W-1:0] dptr, nxt, maddr, len, stride, cyc, cmd, wcnt, ccnt, data_q;
    logic              to_dev, word_done, burst_end, last_burst;
    logic [WORD_W-1:0] wb_word;

    assign to_dev     = cmd[CMD_TO_DEV];
    assign burst_end  = (wcnt == len - 1'b1);
    assign last_burst = ((ccnt + 1'b1) >= cyc);
    assign wb_word    = cmd | (WORD_W'(1) << CMD_DESC_OK)
                            | ((nxt & PTR_MASK) == '0 ? (WORD_W'(1) << CMD_ALL_OK) : '0);
    assign word_done  = (state == ST_WR) && (to_dev ? dev_out_ready : mem_ack);

    // drive the memory and device handshakes from the current phase
    always_comb begin
        busy          = (state != ST_IDLE);
        mem_req       = (state == ST_FETCH) || (state == ST_WB)
                        || (state == ST_RD && to_dev) || (state == ST_WR && !to_dev);
        mem_we        = (state == ST_WB) || (state == ST_WR && !to_dev);
        mem_addr      = (state == ST_FETCH) ? dptr + {27'd0, idx, 2'b00}
                      : (state == ST_WB)    ? dptr + CMD_OFFS
                      : maddr;
        mem_wdata     = (state == ST_WB) ? wb_word : data_q;
        dev_in_ready  = (state == ST_RD) && !to_dev;
        dev_out_valid = (state == ST_WR) && to_dev;
        dev_out_data  = data_q;
    end

    // main sequence: fetch, move words, write back, chain or finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; idx <= '0; irq <= 1'b0;
            dptr <= '0; nxt <= '0; maddr <= '0; dev_addr <= '0; len <= '0;
            stride <= '0; cyc <= '0; cmd <= '0; wcnt <= '0; ccnt <= '0; data_q <= '0;
        end else begin
            irq <= 1'b0;
            case (state)
                ST_IDLE: if (go) begin
                    dptr  <= go_ptr;
                    idx   <= '0;
                    state <= ST_FETCH;
                end
                ST_FETCH: if (mem_ack) begin
                    case (idx)
                        3'd0:    nxt      <= mem_rdata;
                        3'd1:    maddr    <= mem_rdata;
                        3'd2:    dev_addr <= mem_rdata;
                        3'd3:    len      <= mem_rdata;
                        3'd4:    stride   <= mem_rdata;
                        3'd5:    cyc      <= mem_rdata;
                        default: cmd      <= mem_rdata;
                    endcase
                    if (idx == 3'(DESC_WORDS - 1)) begin
                        wcnt <= '0;
                        ccnt <= '0;
                        if (stop_pend)      state <= ST_IDLE;
                        else if (len == '0) state <= ST_WB;
                        else                state <= ST_RD;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_RD: if (to_dev ? mem_ack : dev_in_valid) begin
                    data_q <= to_dev ? mem_rdata : dev_in_data;
                    state  <= ST_WR;
                end
                ST_WR: if (word_done) begin
                    if (burst_end) begin
                        wcnt  <= '0;
                        ccnt  <= ccnt + 1'b1;
                        maddr <= maddr + 32'd4 + (stride << 2);
                    end else begin
                        wcnt  <= wcnt + 1'b1;
                        maddr <= maddr + 32'd4;
                    end
                    if (stop_pend)                    state <= ST_IDLE;
                    else if (burst_end && last_burst) state <= ST_WB;
                    else                              state <= ST_RD;
                end
                ST_WB: if (mem_ack) begin
                    irq <= cmd[CMD_IRQ_EN] & ~cmd[CMD_IRQ_MSK] & ~stop_pend;
                    if (stop_pend || (nxt & PTR_MASK) == '0) begin
                        state <= ST_IDLE;
                    end else begin
                        dptr  <= nxt & PTR_MASK;
                        idx   <= '0;
                        state <= ST_FETCH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R2
    AST_DEV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_out_valid && !dev_out_ready) |=> (dev_out_valid && $stable(dev_out_data))); // R3
    AST_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_in_ready && dev_out_valid));                                 // R4
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);                                                     // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !dev_out_valid && !dev_in_ready));          // R9

endmodule

// File: rtl/chain_dma.sv
// Top of the descriptor-chained DMA channel: the control decoder feeds the
// sequencer. Assumes a single requester on the memory port.
module chain_dma
    import chain_dma_pkg::*;
#(
    parameter int ID_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [31:0]       ctl_wdata,
    output logic              busy,
    output logic [ID_W-1:0]   chan_id,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic [31:0]       dev_addr,
    input  logic              dev_in_valid,
    input  logic [31:0]       dev_in_data,
    output logic              dev_in_ready,
    output logic              dev_out_valid,
    output logic [31:0]       dev_out_data,
    input  logic              dev_out_ready,
    output logic              irq
);

    logic              go, stop_pend, seq_busy;
    logic [WORD_W-1:0] go_ptr;

    chain_dma_ctl #(.ID_W(ID_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .seq_busy(seq_busy), .go(go), .go_ptr(go_ptr), .chan_id(chan_id),
        .stop_pend(stop_pend), .busy_any(busy)
    );

    chain_dma_seq u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .go_ptr(go_ptr), .stop_pend(stop_pend),
        .busy(seq_busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .dev_addr(dev_addr), .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data),
        .dev_in_ready(dev_in_ready), .dev_out_valid(dev_out_valid),
        .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready), .irq(irq)
    );

endmodule

// File: tb/chain_dma_test.sv
// Directed bench: a 256-word memory answering one cycle after each request,
// a device source producing A0000000 + n and a device sink recording words.
module chain_dma_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic        busy, mem_req, mem_we, mem_ack, dev_in_valid, dev_in_ready;
    logic        dev_out_valid, dev_out_ready, irq;
    logic [1:0]  chan_id;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, dev_addr, dev_in_data, dev_out_data;

    logic [31:0] mem [256];
    logic [31:0] sink [64];
    int          sink_n, src_n, irq_n;
    logic [7:0]  tick;
    logic        tb_we = 1'b0, fill = 1'b0, clr = 1'b0;
    logic [7:0]  tb_waddr = '0;
    logic [31:0] tb_wdata = '0;
    logic        src_en = 1'b0, src_slow = 1'b0, sink_slow = 1'b0;
    int          checks = 0, failures = 0;

    always #10 clk = ~clk;

    chain_dma uut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .busy(busy), .chan_id(chan_id), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .dev_addr(dev_addr), .dev_in_valid(dev_in_valid),
        .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
        .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data),
        .dev_out_ready(dev_out_ready), .irq(irq)
    );

    assign dev_in_valid  = src_en && (!src_slow || tick[1:0] == 2'd0);
    assign dev_in_data   = 32'hA000_0000 + 32'(src_n);
    assign dev_out_ready = !sink_slow || tick[0];

    // memory, device and interrupt models
    always @(posedge clk) begin
        tick <= tick + 8'd1;
        if (!rst_n) begin
            mem_ack <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                mem_rdata <= mem[mem_addr[9:2]];
                if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            end
        end
        if (fill) for (int i = 0; i < 256; i++) mem[i] <= 32'hDEAD_0000 | 32'(i);
        if (tb_we) mem[tb_waddr] <= tb_wdata;
        if (clr) begin
            sink_n <= 0; src_n <= 0; irq_n <= 0;
        end else begin
            if (dev_out_valid && dev_out_ready) begin
                sink[sink_n[5:0]] <= dev_out_data;
                sink_n <= sink_n + 1;
            end
            if (dev_in_valid && dev_in_ready) src_n <= src_n + 1;
            if (irq) irq_n <= irq_n + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int w, input logic [31:0] d);
        @(negedge clk); tb_we = 1'b1; tb_waddr = 8'(w); tb_wdata = d;
        @(negedge clk); tb_we = 1'b0;
    endtask

    task automatic put_desc(input int w, input logic [31:0] nx, input logic [31:0] ma,
                            input logic [31:0] da, input logic [31:0] ln,
                            input logic [31:0] st, input logic [31:0] cy,
                            input logic [31:0] cm);
        wr(w, nx); wr(w + 1, ma); wr(w + 2, da); wr(w + 3, ln);
        wr(w + 4, st); wr(w + 5, cy); wr(w + 6, cm);
    endtask

    task automatic prep();
        @(negedge clk); fill = 1'b1; clr = 1'b1;
        @(negedge clk); fill = 1'b0; clr = 1'b0;
        src_slow = 1'b0; sink_slow = 1'b0; src_en = 1'b1;
    endtask

    task automatic ctl(input logic [31:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 5000 && busy; n++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R9 reset busy", 32'(busy), 0);
        chk("R8 reset irq", 32'(irq), 0);
        chk("R9 reset mem_req", 32'(mem_req), 0);
    endtask

    task automatic t_single_m2d();
        prep();
        for (int i = 0; i < 4; i++) wr(128 + i, 32'h1000 + 32'(i));
        put_desc(0, 0, 32'h200, 32'hBEEF_0010, 4, 0, 1, 32'h1002);
        ctl(32'h0000_000A);
        chk("R1 busy after start", 32'(busy), 1);
        chk("R1 chan_id", 32'(chan_id), 2);
        wait_idle();
        chk("R3 sink count", 32'(sink_n), 4);
        for (int i = 0; i < 4; i++) chk("R3 sink word", sink[i], 32'h1000 + 32'(i));
        chk("R2 dev_addr", dev_addr, 32'hBEEF_0010);
        chk("R7 last writeback", mem[6], 32'h100E);
        chk("R8 irq count", 32'(irq_n), 1);
        chk("R9 idle at end", 32'(busy), 0);
    endtask

    task automatic t_chain_d2m();
        prep();
        put_desc(0, 32'h40, 32'h240, 32'h10, 3, 0, 1, 32'h0002);
        put_desc(16, 0, 32'h280, 32'h10, 2, 0, 1, 32'h0003);
        ctl(32'h0000_0009);
        wait_idle();
        for (int i = 0; i < 3; i++) chk("R4 first buffer", mem[144 + i], 32'hA000_0000 + 32'(i));
        chk("R5 word past length", mem[147], 32'hDEAD_0093);
        for (int i = 0; i < 2; i++) chk("R9 chained buffer", mem[160 + i], 32'hA000_0003 + 32'(i));
        chk("R7 mid writeback", mem[6], 32'h0006);
        chk("R7 end writeback", mem[22], 32'h000F);
        chk("R8 masked irq count", 32'(irq_n), 1);
    endtask

    task automatic t_chain4();
        prep();
        sink_slow = 1'b1;
        for (int i = 0; i < 8; i++) wr(128 + i, 32'h5000 + 32'(i));
        put_desc(0, 32'h40, 32'h200, 32'h20, 2, 2, 2, 32'h1002);
        put_desc(16, 32'h80, 32'h2C0, 32'h20, 0, 0, 1, 32'h0002);
        put_desc(32, 32'hC0, 32'h300, 32'h20, 1, 0, 1, 32'h0002);
        put_desc(48, 0, 32'h210, 32'h20, 1, 0, 1, 32'h1002);
        ctl(32'h0000_0008);
        wait_idle();
        chk("R6 sink count", 32'(sink_n), 5);
        chk("R6 burst1 w0", sink[0], 32'h5000);
        chk("R6 burst1 w1", sink[1], 32'h5001);
        chk("R6 burst2 w0", sink[2], 32'h5004);
        chk("R6 burst2 w1", sink[3], 32'h5005);
        chk("R9 fourth desc word", sink[4], 32'h5004);
        chk("R5 zero length no write", mem[176], 32'hDEAD_00B0);
        chk("R5 zero length writeback", mem[22], 32'h0006);
        chk("R4 third desc word", mem[192], 32'hA000_0000);
        chk("R7 first writeback", mem[6], 32'h1006);
        chk("R7 final writeback", mem[54], 32'h100E);
        chk("R8 irq count", 32'(irq_n), 4);
    endtask

    task automatic t_stop();
        int k;
        prep();
        src_slow = 1'b1;
        put_desc(32, 0, 32'h200, 32'h30, 40, 0, 1, 32'h0002);
        put_desc(16, 0, 32'h200, 32'h30, 2, 0, 1, 32'h1002);
        ctl(32'h0000_008B);
        repeat (20) @(negedge clk);
        ctl(32'h0000_0048);
        chk("R11 chan_id kept", 32'(chan_id), 3);
        repeat (20) @(negedge clk);
        chk("R10 still busy before stop", 32'(busy), 1);
        ctl(32'h0000_0010);
        wait_idle();
        k = src_n;
        chk("R10 stopped early", 32'(k > 0 && k < 40), 1);
        chk("R10 last word written", mem[128 + k - 1], 32'hA000_0000 + 32'(k - 1));
        chk("R10 no word after stop", mem[128 + k], 32'hDEAD_0000 | 32'(128 + k));
        chk("R10 no writeback", mem[38], 32'h0002);
        chk("R10 no irq", 32'(irq_n), 0);
        repeat (20) @(negedge clk);
        chk("R11 no second run", 32'(busy), 0);
        chk("R11 nothing sent", 32'(sink_n), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_m2d();
        t_chain_d2m();
        t_chain4();
        t_stop();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule